// File: doc/BRIEF.md
# Serial RAM Download Loader

This block fills on-chip RAM from the receive side of a serial port after a boot reset, then reports that the loaded program may run. Every byte from the receiver goes to RAM at the next address, starting from zero. The processor, the UART and the RAM array sit outside the block. The loader drives only the RAM write port, a completion flag, the entry address and the mode of the serial transmit pin.

The download stops in one of two ways. The first is line silence: after the first byte has arrived, a character-period tick is counted, and the fourth tick in a row with no byte in between ends the load. The second is a full RAM: the byte written to the last address of the configured RAM size ends the load at once. When the load ends, the done flag rises and the entry address handed to the processor is zero. While the load is still running, the transmit pin is held in open-drain mode, so an external pull-up is needed on that pin.

Top module: `ram_download_loader`

## Requirements
- R1: After a synchronous reset, done is 0, ramWe is 0 and txOpenDrain is 1.
- R2: A byte taken on rxValid before done appears on the RAM port one cycle later. In that cycle ramWe is 1, ramData holds the byte, and ramAddr is 0 for the first byte and one higher for each byte after it.
- R3: Once at least one byte has arrived, four charTick pulses with no rxValid among them make done rise in the cycle after the fourth tick. Done then stays high until reset.
- R4: Before the first byte arrives, charTick pulses are ignored and done stays 0.
- R5: A received byte restarts the silence count, so only ticks after the latest byte count toward the four.
- R6: The byte written to address ramSize-1 ends the load: done is 1 in the same cycle as that write on the RAM port.
- R7: A byte that arrives while done is 1 causes no RAM write (ramWe stays 0).
- R8: While done is 1, startAddr is 0.
- R9: txOpenDrain is 1 while the load is running and 0 once done is 1.
- R10: A reset in the middle of a load makes the next received byte go to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxValid | input | 1 | One-cycle strobe for a received byte |
| rxData | input | DATA_W | Received byte |
| charTick | input | 1 | One pulse per character period |
| ramSize | input | ADDR_W+1 | Configured RAM size in bytes, 1 to 2^ADDR_W |
| ramAddr | output | ADDR_W | RAM write address |
| ramData | output | DATA_W | RAM write data |
| ramWe | output | 1 | RAM write enable |
| done | output | 1 | Load finished |
| startAddr | output | ADDR_W | Entry address for the processor |
| txOpenDrain | output | 1 | Transmit pin in open-drain mode |

## Verification
The assertions take for granted that ramSize is held steady for the whole load and lies between 1 and 2^ADDR_W. Without that, the last-address check could compare against a moving limit. They also assume that rxValid is a single-cycle strobe per byte. The bench sets ramSize only while reset is asserted, and it raises rxValid and charTick for one cycle at a time, on the falling edge. Tick and byte pulses never share a cycle, so which one wins a collision is never tested.

// File: rtl/loader_pkg.sv
package loader_pkg;
  // Strobes from the sequencer to the write datapath
  typedef struct packed {
    logic writeByte;   // capture rxData and advance the write address
  } loaderStrobes_t;

  typedef enum logic [1:0] {
    LD_WAIT_FIRST = 2'd0,
    LD_RECEIVING  = 2'd1,
    LD_FINISHED   = 2'd2
  } loaderState_t;
endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
#(
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rxValid,
  input  logic           charTick,
  input  logic           lastHit,
  output loaderStrobes_t strobes,
  output logic           done
);
  localparam int CNT_W = $clog2(TIMEOUT_CHARS + 1);

  loaderState_t stateQ, stateD;
  logic [CNT_W-1:0] tickCntQ, tickCntD;

  always_comb begin
    stateD            = stateQ;
    tickCntD          = tickCntQ;
    strobes.writeByte = 1'b0;
    unique case (stateQ)
      LD_WAIT_FIRST, LD_RECEIVING: begin
        if (rxValid) begin
          strobes.writeByte = 1'b1;
          tickCntD          = '0;
          stateD            = lastHit ? LD_FINISHED : LD_RECEIVING;
        end else if (charTick && stateQ == LD_RECEIVING) begin
          if (tickCntQ == CNT_W'(TIMEOUT_CHARS - 1)) stateD = LD_FINISHED;
          else tickCntD = tickCntQ + 1'b1;
        end
      end
      default: stateD = LD_FINISHED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= LD_WAIT_FIRST;
      tickCntQ <= '0;
    end else begin
      stateQ   <= stateD;
      tickCntQ <= tickCntD;
    end
  end

  assign done = (stateQ == LD_FINISHED);
endmodule

// File: rtl/loader_datapath.sv
module loader_datapath
  import loader_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  loaderStrobes_t    strobes,
  input  logic [DATA_W-1:0] rxData,
  input  logic [ADDR_W:0]   ramSize,
  output logic              lastHit,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic              ramWe
);
  logic [ADDR_W-1:0] nextAddrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      nextAddrQ <= '0;
      ramAddr   <= '0;
      ramData   <= '0;
      ramWe     <= 1'b0;
    end else begin
      ramWe <= strobes.writeByte;
      if (strobes.writeByte) begin
        ramAddr   <= nextAddrQ;
        ramData   <= rxData;
        nextAddrQ <= nextAddrQ + 1'b1;
      end
    end
  end

  // The address about to be written is the highest one in the configured RAM
  assign lastHit = ({1'b0, nextAddrQ} == (ramSize - 1'b1));
endmodule

// File: rtl/ram_download_loader.sv
module ram_download_loader
  import loader_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              charTick,
  input  logic [ADDR_W:0]   ramSize,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic              ramWe,
  output logic              done,
  output logic [ADDR_W-1:0] startAddr,
  output logic              txOpenDrain
);
  loaderStrobes_t strobes;
  logic lastHit;

  loader_ctrl #(.TIMEOUT_CHARS(TIMEOUT_CHARS)) u_ctrl (
    .clk(clk), .rst(rst), .rxValid(rxValid), .charTick(charTick),
    .lastHit(lastHit), .strobes(strobes), .done(done)
  );

  loader_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .rxData(rxData),
    .ramSize(ramSize), .lastHit(lastHit), .ramAddr(ramAddr),
    .ramData(ramData), .ramWe(ramWe)
  );

  assign startAddr   = '0;
  assign txOpenDrain = ~done;
endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              rxValid,
  input logic [ADDR_W:0]   ramSize,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramWe,
  input logic              done
);
  assert_write_follows_byte_R2: assert property (@(posedge clk) disable iff (rst)
    (rxValid && !done) |=> ramWe);

  assert_done_holds_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_last_write_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (ramWe && ({1'b0, ramAddr} == ramSize - 1'b1)) |-> done);

  assert_no_write_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !ramWe);
endmodule

bind ram_download_loader loader_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst(rst), .rxValid(rxValid), .ramSize(ramSize),
  .ramAddr(ramAddr), .ramWe(ramWe), .done(done)
);

// File: tb/sim_ram_download_loader.sv
`timescale 1ns/1ps
module sim_ram_download_loader;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;

  logic clk = 1'b0, rst = 1'b1, rxValid = 1'b0, charTick = 1'b0;
  logic [DATA_W-1:0] rxData = '0;
  logic [ADDR_W:0]   ramSize = 10'd512;
  logic [ADDR_W-1:0] ramAddr, startAddr;
  logic [DATA_W-1:0] ramData;
  logic ramWe, done, txOpenDrain;
  int vectors = 0, misses = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ram_download_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxData(rxData),
    .charTick(charTick), .ramSize(ramSize), .ramAddr(ramAddr),
    .ramData(ramData), .ramWe(ramWe), .done(done),
    .startAddr(startAddr), .txOpenDrain(txOpenDrain)
  );

  task automatic chk(input int act, input int exp, input string req);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int size);
    @(negedge clk);
    rst = 1'b1; ramSize = (ADDR_W+1)'(size);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one byte; at the next falling edge the RAM port shows the write
  task automatic sendByte(input int data, input bit expWe, input int expAddr, input string req);
    rxValid = 1'b1; rxData = DATA_W'(data);
    @(negedge clk);
    rxValid = 1'b0;
    chk(ramWe, expWe, req);
    if (expWe) begin
      chk(ramAddr, expAddr, req);
      chk(ramData, data, req);
    end
    @(negedge clk);
  endtask

  task automatic sendTick();
    charTick = 1'b1;
    @(negedge clk);
    charTick = 1'b0;
  endtask

  task automatic t_reset();
    doReset(512);
    chk(done, 0, "R1 done");
    chk(ramWe, 0, "R1 ramWe");
    chk(txOpenDrain, 1, "R1 txOpenDrain");
  endtask

  task automatic t_idle_ticks();
    doReset(512);
    for (int i = 0; i < 10; i++) sendTick();
    @(negedge clk);
    chk(done, 0, "R4 ticks before first byte");
    sendByte(8'h11, 1, 0, "R4 first byte still lands at 0");
  endtask

  task automatic t_stream_timeout();
    doReset(512);
    for (int i = 0; i < 5; i++) sendByte(8'hA0 + i * 7, 1, i, "R2 sequential write");
    repeat (3) sendTick();
    chk(done, 0, "R5 three ticks not enough");
    sendByte(8'h5C, 1, 5, "R5 byte restarts count");
    repeat (3) sendTick();
    chk(done, 0, "R5 count restarted");
    chk(txOpenDrain, 1, "R9 active open drain");
    sendTick();
    chk(done, 1, "R3 fourth silent tick");
    chk(txOpenDrain, 0, "R9 released after done");
    chk(startAddr, 0, "R8 entry address");
    sendByte(8'h77, 0, 0, "R7 byte after done ignored");
    chk(done, 1, "R3 done sticky");
  endtask

  task automatic t_fill();
    doReset(8);
    for (int i = 0; i < 7; i++) sendByte(i + 1, 1, i, "R2 fill");
    chk(done, 0, "R6 not done before last address");
    rxValid = 1'b1; rxData = 8'hEE;
    @(negedge clk);
    rxValid = 1'b0;
    chk(ramWe, 1, "R6 last write");
    chk(ramAddr, 7, "R6 last address");
    chk(done, 1, "R6 done with last write");
    @(negedge clk);
    sendByte(8'h99, 0, 0, "R7 overflow byte ignored");
  endtask

  task automatic t_mid_reset();
    doReset(512);
    for (int i = 0; i < 3; i++) sendByte(i, 1, i, "R2 pre-reset");
    doReset(512);
    sendByte(8'h42, 1, 0, "R10 address back to zero");
  endtask

  initial begin
    t_reset();
    t_idle_ticks();
    t_stream_timeout();
    t_fill();
    t_mid_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      vectors++; misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule